// File: doc/BRIEF.md
# Toggle Bit Polling Controller

This block runs on the host side of a parallel flash device. It decides when an embedded program or erase operation has finished. A one-cycle `start` pulse begins a poll. The controller then issues status reads in pairs over a request/response handshake. It keeps the toggle bit from the first read of each pair and compares it with the toggle bit from the second read. A bit that holds steady means the operation is over. A bit that keeps flipping means the device is still busy, so another pair is read.

The controller also watches the exceeded-time-limit flag (bit 5) of the second read in a pair. When that flag is high while the toggle bit still flips, the controller does not signal an error straight away. It reads exactly one more pair first. This extra pair tells an operation that ended just as the flag rose apart from a real failure.

Every poll ends with a one-cycle `done` pulse. It carries either `pass`, or `reset_req`, which asks the surrounding logic to send the reset command to the flash. An optional pair budget ends a poll that never resolves, with `timeout` and `reset_req`. `abort` drops a poll at once, and the next `start` begins again from a fresh first pair.

Top module: `tbit_poll_ctrl`

## Requirements
- R1: While reset is held and after it is released, `busy`, `done`, `pass`, `reset_req`, `timeout`, `rd_req_valid` and `rd_rsp_ready` are all low.
- R2: A `start` pulse while idle raises `busy` in the next cycle. `busy` stays high until the cycle in which `done` is high, and is low in that cycle. A `start` pulse while busy has no effect on the reads or on the outcome.
- R3: A read request is held on `rd_req_valid` until `rd_req_ready` accepts it. After that, `rd_rsp_ready` is high until one response is taken with `rd_rsp_valid`. Only one read is ever outstanding, and `rd_req_valid` and `rd_rsp_ready` are never high together.
- R4: When the toggle bit is equal in both reads of a pair, the poll ends with `done` and `pass` high and `reset_req` low.
- R5: When the toggle bit differs across a pair and bit 5 of the second read is low, the controller issues another pair without raising `done`.
- R6: When the toggle bit differs across a pair and bit 5 of the second read is high, exactly one recheck pair follows. A steady toggle bit in that recheck pair ends the poll with `pass`. Bit 5 of the first read of a pair is ignored.
- R7: If the toggle bit still differs in the recheck pair, the poll ends with `done` and `reset_req` high and `pass` low.
- R8: `sel_dq2` is sampled with `start`. A value of 1 makes data bit 2 the monitored toggle bit, and 0 makes it bit 6. The other bit is ignored.
- R9: When `MAX_PAIRS` is non-zero, the `MAX_PAIRS`-th consecutive toggling pair with bit 5 low ends the poll with `done`, `reset_req` and `timeout` high and `pass` low. A steady pair that arrives after `MAX_PAIRS`-1 toggling pairs still passes.
- R10: `abort` while busy returns the controller to idle in the next cycle with no `done`. The following poll starts from a first pair with no recheck pending and an empty pair count.
- R11: `done`, `pass`, `reset_req` and `timeout` last one cycle. `pass`, `reset_req` and `timeout` are high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a poll (pulse) |
| abort | input | 1 | Abandon the poll in progress |
| sel_dq2 | input | 1 | 1: watch data bit 2, 0: watch data bit 6 |
| rd_req_valid | output | 1 | Status read request |
| rd_req_ready | input | 1 | Bus accepts the read request |
| rd_rsp_valid | input | 1 | Read data present |
| rd_rsp_ready | output | 1 | Controller takes the read data |
| rd_rsp_data | input | DATA_W | Status byte from the flash |
| busy | output | 1 | Poll in progress |
| done | output | 1 | Poll finished (one cycle) |
| pass | output | 1 | Operation completed successfully (with done) |
| reset_req | output | 1 | Reset command must be issued (with done) |
| timeout | output | 1 | Pair budget exhausted (with done) |

## Verification
The bench plants patterns where a wrong decision becomes visible: a late completion after bit 5 rises, a recheck that still toggles, and bit 5 set only on the first read of a pair. A design that reads bit 5 from the wrong read, or skips the recheck, ends with the wrong verdict. The design would then either consume a read the bench never supplied or leave a planned read unused. The bench also checks that the pair budget ends a poll exactly at its limit and not one pair earlier. A selection test toggles only the unwatched bit, so a design that swaps the bits never finishes cleanly. An abort leaves a recheck armed on purpose: a design that keeps that state fails the next poll on its first toggling pair.

// File: rtl/tbit_pkg.sv
package tbit_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ_A,
    ST_RSP_A,
    ST_REQ_B,
    ST_RSP_B
  } poll_state_t;
endpackage

// File: rtl/tbit_pair_cmp.sv
module tbit_pair_cmp #(
  parameter int DATA_W   = 8,
  parameter int BIT_LO   = 6,
  parameter int BIT_HI   = 2,
  parameter int LIMIT_IX = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_sel,
  input  logic              sel_in,
  input  logic              cap_first,
  input  logic [DATA_W-1:0] data,
  output logic              toggled,
  output logic              limit_hit
);
  logic sel_q;
  logic first_q;
  logic cur_bit;

  assign cur_bit   = sel_q ? data[BIT_HI] : data[BIT_LO];
  assign toggled   = cur_bit ^ first_q;
  assign limit_hit = data[LIMIT_IX];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q   <= 1'b0;
      first_q <= 1'b0;
    end else begin
      if (load_sel)  sel_q   <= sel_in;
      if (cap_first) first_q <= cur_bit;
    end
  end
endmodule

// File: rtl/tbit_pair_budget.sv
module tbit_pair_budget #(
  parameter int MAX_PAIRS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bump,
  output logic last
);
  generate
    if (MAX_PAIRS == 0) begin : g_unbounded
      assign last = 1'b0;
    end else begin : g_bounded
      localparam int CW = $clog2(MAX_PAIRS + 1);
      localparam logic [CW-1:0] LAST_V = CW'(MAX_PAIRS - 1);
      logic [CW-1:0] cnt_q;
      assign last = (cnt_q == LAST_V);
      always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (clear)        cnt_q <= '0;
        else if (bump && !last) cnt_q <= cnt_q + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/tbit_poll_fsm.sv
module tbit_poll_fsm
  import tbit_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic abort,
  input  logic rd_req_ready,
  input  logic rd_rsp_valid,
  input  logic toggled,
  input  logic limit_hit,
  input  logic budget_last,
  output logic rd_req_valid,
  output logic rd_rsp_ready,
  output logic busy,
  output logic load_sel,
  output logic cap_first,
  output logic bump,
  output logic done,
  output logic pass,
  output logic reset_req,
  output logic timeout
);
  poll_state_t st_q;
  logic recheck_q;
  logic second_in;

  assign rd_req_valid = (st_q == ST_REQ_A) || (st_q == ST_REQ_B);
  assign rd_rsp_ready = (st_q == ST_RSP_A) || (st_q == ST_RSP_B);
  assign busy         = (st_q != ST_IDLE);
  assign load_sel     = (st_q == ST_IDLE) && start;
  assign cap_first    = (st_q == ST_RSP_A) && rd_rsp_valid && !abort;
  assign second_in    = (st_q == ST_RSP_B) && rd_rsp_valid && !abort;
  assign bump         = second_in && toggled && !recheck_q && !limit_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      recheck_q <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
      reset_req <= 1'b0;
      timeout   <= 1'b0;
    end else begin
      done      <= 1'b0;
      pass      <= 1'b0;
      reset_req <= 1'b0;
      timeout   <= 1'b0;
      if (abort && st_q != ST_IDLE) begin
        st_q      <= ST_IDLE;
        recheck_q <= 1'b0;
      end else begin
        case (st_q)
          ST_IDLE: if (start) begin
            st_q      <= ST_REQ_A;
            recheck_q <= 1'b0;
          end
          ST_REQ_A: if (rd_req_ready) st_q <= ST_RSP_A;
          ST_RSP_A: if (rd_rsp_valid) st_q <= ST_REQ_B;
          ST_REQ_B: if (rd_req_ready) st_q <= ST_RSP_B;
          ST_RSP_B: if (rd_rsp_valid) begin
            if (!toggled) begin
              st_q <= ST_IDLE;
              done <= 1'b1;
              pass <= 1'b1;
            end else if (recheck_q) begin
              st_q      <= ST_IDLE;
              done      <= 1'b1;
              reset_req <= 1'b1;
            end else if (limit_hit) begin
              recheck_q <= 1'b1;
              st_q      <= ST_REQ_A;
            end else if (budget_last) begin
              st_q      <= ST_IDLE;
              done      <= 1'b1;
              reset_req <= 1'b1;
              timeout   <= 1'b1;
            end else begin
              st_q <= ST_REQ_A;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready && !abort |=> rd_req_valid);
  assert_one_outstanding_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && rd_rsp_ready));
  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_flags_need_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pass || reset_req || timeout) |-> done);
  assert_verdict_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass != reset_req));
  assert_timeout_fails_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (reset_req && !pass));
  assert_idle_on_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && abort |=> !busy && !done);
endmodule

// File: rtl/tbit_poll_ctrl.sv
module tbit_poll_ctrl #(
  parameter int DATA_W    = 8,
  parameter int MAX_PAIRS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              sel_dq2,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic              reset_req,
  output logic              timeout
);
  logic load_sel, cap_first, bump, toggled, limit_hit, budget_last;

  tbit_pair_cmp #(
    .DATA_W(DATA_W), .BIT_LO(6), .BIT_HI(2), .LIMIT_IX(5)
  ) u_cmp (
    .clk(clk), .rst_n(rst_n), .load_sel(load_sel), .sel_in(sel_dq2),
    .cap_first(cap_first), .data(rd_rsp_data),
    .toggled(toggled), .limit_hit(limit_hit)
  );

  tbit_pair_budget #(.MAX_PAIRS(MAX_PAIRS)) u_budget (
    .clk(clk), .rst_n(rst_n), .clear(load_sel), .bump(bump), .last(budget_last)
  );

  tbit_poll_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .rd_req_ready(rd_req_ready), .rd_rsp_valid(rd_rsp_valid),
    .toggled(toggled), .limit_hit(limit_hit), .budget_last(budget_last),
    .rd_req_valid(rd_req_valid), .rd_rsp_ready(rd_rsp_ready), .busy(busy),
    .load_sel(load_sel), .cap_first(cap_first), .bump(bump),
    .done(done), .pass(pass), .reset_req(reset_req), .timeout(timeout)
  );
endmodule

// File: tb/tbit_poll_ctrl_bench.sv
module tbit_poll_ctrl_bench;
  localparam int MAXP = 8;

  typedef struct {
    bit    p;
    bit    r;
    bit    t;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, abort = 1'b0, sel_dq2 = 1'b0;
  logic rd_req_ready = 1'b0, rd_rsp_valid = 1'b0;
  logic [7:0] rd_rsp_data = 8'h00;
  logic rd_req_valid, rd_rsp_ready, busy, done, pass, reset_req, timeout;

  tbit_poll_ctrl #(.DATA_W(8), .MAX_PAIRS(MAXP)) u_tbit_poll_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .sel_dq2(sel_dq2),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_data(rd_rsp_data), .busy(busy), .done(done), .pass(pass),
    .reset_req(reset_req), .timeout(timeout)
  );

  logic [7:0] dq[$];
  exp_t       eq[$];
  int vectors = 0, miscompares = 0, done_seen = 0;
  int abort_after = -1, acc_cnt = 0, outstanding = 0, overlap_err = 0;
  bit tog = 1'b0, after_done = 1'b0, resp_on = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [7:0] mk(bit sel, bit tb, bit d5, bit noise);
    logic [7:0] b = 8'h00;
    if (sel) begin b[2] = tb; b[6] = noise; end
    else     begin b[6] = tb; b[2] = noise; end
    b[5] = d5;
    b[0] = noise;
    return b;
  endfunction

  task automatic push_pair(bit sel, bit toggles, bit d5a, bit d5b);
    bit second = toggles ? ~tog : tog;
    dq.push_back(mk(sel, tog, d5a, 1'b0));
    dq.push_back(mk(sel, second, d5b, 1'b1));
    tog = second;
  endtask

  task automatic run_op(bit sel, bit p, bit r, bit t, string tag, bit extra_start);
    int d0;
    exp_t e;
    e.p = p; e.r = r; e.t = t; e.tag = tag;
    eq.push_back(e);
    acc_cnt = 0;
    sel_dq2 = sel;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2", "busy after start", busy, 1);
    d0 = done_seen;
    if (extra_start) begin
      repeat (3) @(negedge clk);
      sel_dq2 = ~sel;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_seen == d0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // responder: models the flash bus with back-pressure on requests
  initial begin
    int rdy_ctr = 0;
    bit req_fire = 1'b0, rsp_fire = 1'b0;
    forever begin
      @(negedge clk);
      abort = 1'b0;
      if (rsp_fire) begin
        void'(dq.pop_front());
        rd_rsp_valid = 1'b0;
        acc_cnt++;
        rsp_fire = 1'b0;
      end
      if (req_fire) begin
        if (outstanding != 0 || rd_rsp_valid) overlap_err++;
        outstanding++;
        req_fire = 1'b0;
      end
      if (abort_after >= 0 && acc_cnt == abort_after) begin
        abort = 1'b1;
        dq.delete();
        rd_rsp_valid = 1'b0;
        rd_req_ready = 1'b0;
        outstanding = 0;
        abort_after = -1;
      end else if (resp_on) begin
        rdy_ctr++;
        rd_req_ready = (rdy_ctr % 3) != 1;
        if (outstanding > 0 && !rd_rsp_valid) begin
          if (dq.size() == 0) begin
            chk(1'b0, "R5", "read beyond planned data", 1, 0);
            dq.push_back(8'h00);
          end
          rd_rsp_valid = 1'b1;
          rd_rsp_data  = dq[0];
          outstanding--;
        end
        req_fire = rd_req_valid && rd_req_ready;
        rsp_fire = rd_rsp_valid && rd_rsp_ready;
      end
    end
  end

  // monitor: pops expected verdicts as done pulses appear
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        done_seen++;
        if (eq.size() == 0) begin
          chk(1'b0, "R10", "unexpected done", 1, 0);
        end else begin
          e = eq.pop_front();
          chk(pass === e.p, e.tag, "pass", pass, e.p);
          chk(reset_req === e.r, e.tag, "reset_req", reset_req, e.r);
          chk(timeout === e.t, e.tag, "timeout", timeout, e.t);
          chk(busy === 1'b0, "R2", "busy in done cycle", busy, 0);
        end
        after_done = 1'b1;
      end else if (after_done) begin
        after_done = 1'b0;
        chk({done, pass, reset_req, timeout} === 4'b0, "R11", "flags one cycle",
            {done, pass, reset_req, timeout}, 0);
        chk(dq.size() == 0, "R5", "planned reads left unused", dq.size(), 0);
        chk(overlap_err == 0, "R3", "request while read outstanding", overlap_err, 0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "R2", "watchdog expired", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int d0;
    repeat (5) @(negedge clk);
    chk({busy, done, pass, reset_req, timeout, rd_req_valid, rd_rsp_ready} === 7'b0,
        "R1", "outputs in reset", {busy, done, pass, reset_req, timeout}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, pass, reset_req, timeout, rd_req_valid, rd_rsp_ready} === 7'b0,
        "R1", "outputs after reset", {busy, done, rd_req_valid, rd_rsp_ready}, 0);
    resp_on = 1'b1;

    // R4: steady on first pair
    push_pair(0, 0, 0, 0);
    run_op(0, 1, 0, 0, "R4", 0);
    // R8: watch bit 2 while bit 6 flips
    push_pair(1, 0, 0, 0);
    run_op(1, 1, 0, 0, "R8", 0);
    // R5: toggling with bit 5 low, then steady
    push_pair(0, 1, 0, 0); push_pair(0, 1, 0, 0); push_pair(0, 1, 0, 0);
    push_pair(0, 0, 0, 0);
    run_op(0, 1, 0, 0, "R5", 0);
    // R6: late completion after bit 5 rises
    push_pair(0, 1, 0, 1); push_pair(0, 0, 1, 1);
    run_op(0, 1, 0, 0, "R6", 0);
    // R6: bit 5 on the first read only does not arm a recheck
    push_pair(1, 1, 1, 0); push_pair(1, 1, 0, 0); push_pair(1, 0, 0, 0);
    run_op(1, 1, 0, 0, "R6", 0);
    // R7: recheck still toggles
    push_pair(0, 1, 0, 1); push_pair(0, 1, 0, 1);
    run_op(0, 0, 1, 0, "R7", 0);
    // R9: budget exhausted exactly at MAXP toggling pairs
    for (int i = 0; i < MAXP; i++) push_pair(0, 1, 0, 0);
    run_op(0, 0, 1, 1, "R9", 0);
    // R9 boundary: one pair short of the budget still passes
    for (int i = 0; i < MAXP - 1; i++) push_pair(1, 1, 0, 0);
    push_pair(1, 0, 0, 0);
    run_op(1, 1, 0, 0, "R9", 0);
    // R2: start while busy is ignored
    push_pair(0, 1, 0, 0); push_pair(0, 1, 0, 0); push_pair(0, 0, 0, 0);
    run_op(0, 1, 0, 0, "R2", 1);

    // R10: abort with a recheck armed, then a fresh poll
    push_pair(0, 1, 0, 1); push_pair(0, 1, 0, 0);
    d0 = done_seen;
    acc_cnt = 0;
    abort_after = 2;
    sel_dq2 = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (abort_after != -1) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(busy === 1'b0, "R10", "busy after abort", busy, 0);
    chk(done_seen == d0, "R10", "done after abort", done_seen - d0, 0);
    push_pair(0, 1, 0, 1); push_pair(0, 0, 0, 0);
    run_op(0, 1, 0, 0, "R10", 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule